// File: doc/BRIEF.md
# Four-State Space-Vector Switching Sequencer

This block plays out a nested four-vector switching pattern over one fixed switching period. It receives four three-phase level vectors and three duty fractions from an upstream vector-selection stage. Once per period it turns the cumulative duties into three transition counts. It then drives the phase level commands through the first, second, third and fourth vector in that order. Each vector is held for its share of the period. The fourth vector takes whatever part of the period is left. Consecutive vectors are expected to differ in a single phase by one level, so each change of state moves one phase up one step.

A free-running counter sets the period length in clock cycles. For example, 20000 cycles of a 100 MHz clock gives a 5 kHz switching frequency. A new vector/duty set may arrive at any time. It is held in a shadow buffer and takes effect only when the counter wraps to zero. A one-cycle `period_start` strobe marks that point. Without a new set, the last set repeats. Until the first set has been taken at a boundary, all three phases sit at level 0.

The control is a five-state machine: `ST_IDLE`, then `ST_V0`, `ST_V1`, `ST_V2` and `ST_V3`, one for each vector. There are three transitions:
- **idle-to-run**: `ST_IDLE` moves to the first state with a nonzero share, at a boundary where a buffered set is waiting.
- **advance**: `ST_Vk` moves forward to the state that owns the next count once the counter crosses that state's threshold. Zero-share states are jumped over.
- **restart**: at every boundary, any `ST_Vk` returns to the first state that owns count 0 of the new period.

Top module: `svm_state_sequencer`

## Requirements
- R1: After reset, `lvl_a`, `lvl_b` and `lvl_c` are 0 and `period_start` is 0. The levels stay 0 for every cycle until the first loaded set has been taken at a period boundary.
- R2: The counter runs from 0 to P-1, where P is `period_cycles` sampled at the previous wrap, and then wraps to 0. `period_start` is high for exactly the cycle in which the count is 0. A change of `period_cycles` in mid-period therefore first sets the length of the following period.
- R3: For k = 1, 2, 3, the transition count Tk is (Ck·P + 2^(DUTY_W-1)) >> DUTY_W. Ck is the sum of the first k duties, so half a cycle rounds up.
- R4: In a running period, the output is `vec0` while count < T1, `vec1` while count < T2, `vec2` while count < T3, and `vec3` for the rest. Each vector is packed with phase a in bits [LVL_W-1:0], phase b in bits [2·LVL_W-1:LVL_W] and phase c in the top LVL_W bits. Levels are unsigned.
- R5: A cumulative duty above full scale (2^DUTY_W) is clamped to full scale. The later states then get no cycles, and the fourth vector holds only what remains.
- R6: A state whose duty is zero produces no output cycle. The sequence goes straight to the next state that has a nonzero share.
- R7: A set loaded by a one-cycle `load` pulse does not change the period in progress. It takes effect at the next wrap. A load that falls in the wrap cycle itself waits for the wrap after that.
- R8: If no new set has been loaded, the active set and its transition counts repeat in every following period. The counts are recomputed from the current P.
- R9: Within a period the state only moves forward through V0, V1, V2, V3. It never returns to an earlier vector before the next `period_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cycles | input | CNT_W | Period length in clock cycles, taken at each wrap |
| load | input | 1 | One-cycle pulse that captures the vectors and duties into the shadow buffer |
| vec0 | input | 3*LVL_W | First vector (all phases at their lower levels) |
| vec1 | input | 3*LVL_W | Second vector |
| vec2 | input | 3*LVL_W | Third vector |
| vec3 | input | 3*LVL_W | Fourth vector (all phases at their upper levels) |
| duty0 | input | DUTY_W | Share of the first vector, in units of 2^-DUTY_W |
| duty1 | input | DUTY_W | Share of the second vector |
| duty2 | input | DUTY_W | Share of the third vector |
| lvl_a | output | LVL_W | Level command for phase a |
| lvl_b | output | LVL_W | Level command for phase b |
| lvl_c | output | LVL_W | Level command for phase c |
| period_start | output | 1 | High for one cycle at count 0 of every period |

## Verification
The embedded properties watch four things on every cycle:
- the counter stays below the latched period, and the strobe coincides with count zero;
- the registered thresholds stay ordered;
- the state machine never steps back within a period;
- the machine leaves `ST_IDLE` only on a strobe cycle and only once a set has been taken.

Other behaviours can only be shown by the scoreboard scenarios, because they depend on the numbers fed in. These are the exact threshold values with their rounding, clamping of over-full duty sums, skipping of zero-share states, repetition of a set, the one-period delay of a mid-period load, and a period-length change.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;

    localparam int NUM_PHASES = 3;
    localparam int NUM_VECS   = 4;
    localparam int NUM_EDGES  = NUM_VECS - 1;

    // Encoding order matters: the forward-only check compares these values.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_V0   = 3'd1,
        ST_V1   = 3'd2,
        ST_V2   = 3'd3,
        ST_V3   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/svm_period_timer.sv
module svm_period_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_cycles,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             start
);

    logic [CNT_W-1:0] per_q;
    logic [CNT_W:0]   count_inc;

    assign count_inc = {1'b0, count} + (CNT_W+1)'(1);
    // Last cycle of the period; a latched length of 0 behaves like 1.
    assign wrap      = (count_inc >= {1'b0, per_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            per_q <= '0;
            start <= 1'b0;
        end else if (wrap) begin
            count <= '0;
            per_q <= period_cycles;
            start <= 1'b1;
        end else begin
            count <= count_inc[CNT_W-1:0];
            start <= 1'b0;
        end
    end

    assert_count_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != '0) |-> (count < per_q));

    assert_strobe_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (count == '0));

endmodule

// File: rtl/svm_threshold_calc.sv
module svm_threshold_calc
    import svm_seq_pkg::*;
#(
    parameter int DUTY_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic [NUM_EDGES-1:0][DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]                 period,
    output logic [NUM_EDGES-1:0][CNT_W-1:0]  thr
);

    localparam int SUM_W  = DUTY_W + 2;
    localparam int PROD_W = SUM_W + CNT_W;
    localparam logic [SUM_W-1:0]  FULL = SUM_W'(1) << DUTY_W;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (DUTY_W - 1);

    logic [SUM_W-1:0]  cum  [NUM_EDGES];
    logic [SUM_W-1:0]  sat  [NUM_EDGES];
    logic [PROD_W-1:0] prod [NUM_EDGES];

    always_comb begin
        for (int k = 0; k < NUM_EDGES; k++) begin
            if (k == 0) cum[k] = SUM_W'(duty[k]);
            else        cum[k] = cum[k-1] + SUM_W'(duty[k]);
            sat[k]  = (cum[k] > FULL) ? FULL : cum[k];
            prod[k] = PROD_W'(sat[k]) * PROD_W'(period) + HALF;
            thr[k]  = prod[k][DUTY_W +: CNT_W];
        end
    end

endmodule

// File: rtl/svm_state_sequencer.sv
module svm_state_sequencer
    import svm_seq_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int DUTY_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     period_cycles,
    input  logic                 load,
    input  logic [3*LVL_W-1:0]   vec0,
    input  logic [3*LVL_W-1:0]   vec1,
    input  logic [3*LVL_W-1:0]   vec2,
    input  logic [3*LVL_W-1:0]   vec3,
    input  logic [DUTY_W-1:0]    duty0,
    input  logic [DUTY_W-1:0]    duty1,
    input  logic [DUTY_W-1:0]    duty2,
    output logic [LVL_W-1:0]     lvl_a,
    output logic [LVL_W-1:0]     lvl_b,
    output logic [LVL_W-1:0]     lvl_c,
    output logic                 period_start
);

    localparam int VEC_W = NUM_PHASES * LVL_W;

    logic [VEC_W-1:0]                  pend_vec [NUM_VECS];
    logic [VEC_W-1:0]                  act_vec  [NUM_VECS];
    logic [NUM_EDGES-1:0][DUTY_W-1:0]  pend_duty, act_duty, src_duty;
    logic [NUM_EDGES-1:0][CNT_W-1:0]   nxt_thr, thr_q;
    logic                              pend_ok, running;
    logic [CNT_W-1:0]                  count;
    logic                              wrap;
    logic [VEC_W-1:0]                  sel_vec;
    seq_state_e                        state_q, state_d;

    svm_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_cycles(period_cycles),
        .count        (count),
        .wrap         (wrap),
        .start        (period_start)
    );

    // Thresholds for the coming period: from the waiting set, else from the active set.
    assign src_duty = pend_ok ? pend_duty : act_duty;

    svm_threshold_calc #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_thr (
        .duty  (src_duty),
        .period(period_cycles),
        .thr   (nxt_thr)
    );

    function automatic seq_state_e pick(input logic [CNT_W-1:0] c,
                                        input logic [NUM_EDGES-1:0][CNT_W-1:0] t);
        if (c < t[0])      return ST_V0;
        else if (c < t[1]) return ST_V1;
        else if (c < t[2]) return ST_V2;
        return ST_V3;
    endfunction

    // Shadow buffer: written on load at any time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VECS; i++) pend_vec[i] <= '0;
            pend_duty <= '0;
            pend_ok   <= 1'b0;
        end else begin
            if (load) begin
                pend_vec[0] <= vec0;
                pend_vec[1] <= vec1;
                pend_vec[2] <= vec2;
                pend_vec[3] <= vec3;
                pend_duty   <= {duty2, duty1, duty0};
            end
            if (load)      pend_ok <= 1'b1;
            else if (wrap) pend_ok <= 1'b0;
        end
    end

    // Active set: swapped only at the wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VECS; i++) act_vec[i] <= '0;
            act_duty <= '0;
            thr_q    <= '0;
            running  <= 1'b0;
        end else if (wrap) begin
            if (pend_ok) begin
                for (int i = 0; i < NUM_VECS; i++) act_vec[i] <= pend_vec[i];
                act_duty <= pend_duty;
                running  <= 1'b1;
            end
            if (pend_ok || running) thr_q <= nxt_thr;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        if (wrap) begin
            if (pend_ok || running) state_d = pick('0, nxt_thr);
        end else if (running) begin
            state_d = pick(count + CNT_W'(1), thr_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: sel_vec = '0;
            ST_V0:   sel_vec = act_vec[0];
            ST_V1:   sel_vec = act_vec[1];
            ST_V2:   sel_vec = act_vec[2];
            ST_V3:   sel_vec = act_vec[3];
            default: sel_vec = '0;
        endcase
        lvl_a = sel_vec[LVL_W-1:0];
        lvl_b = sel_vec[2*LVL_W-1:LVL_W];
        lvl_c = sel_vec[VEC_W-1:2*LVL_W];
    end

    assert_idle_until_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (state_q == ST_IDLE));

    assert_leave_idle_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> period_start);

    assert_thresholds_ordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (thr_q[0] <= thr_q[1] && thr_q[1] <= thr_q[2]));

    assert_forward_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && $past(state_q) != ST_IDLE) |-> (state_q >= $past(state_q)));

endmodule

// File: tb/test_svm_state_sequencer.sv
module test_svm_state_sequencer;

    localparam int LVL_W  = 3;
    localparam int DUTY_W = 8;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CNT_W-1:0]  period_cycles;
    logic              load;
    logic [8:0]        vec0, vec1, vec2, vec3;
    logic [7:0]        duty0, duty1, duty2;
    logic [2:0]        lvl_a, lvl_b, lvl_c;
    logic              period_start;

    always #4 clk = ~clk;

    svm_state_sequencer #(.LVL_W(LVL_W), .DUTY_W(DUTY_W), .CNT_W(CNT_W)) i_svm_state_sequencer (
        .clk(clk), .rst_n(rst_n), .period_cycles(period_cycles), .load(load),
        .vec0(vec0), .vec1(vec1), .vec2(vec2), .vec3(vec3),
        .duty0(duty0), .duty1(duty1), .duty2(duty2),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .period_start(period_start)
    );

    typedef struct {
        logic [2:0] a;
        logic [2:0] b;
        logic [2:0] c;
        logic       stb;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    logic [8:0] m_act [4];
    logic [8:0] m_pend [4];
    int         m_actd [3];
    int         m_pendd [3];
    bit         m_pend_ok = 0;
    bit         m_run = 0;

    task automatic load_set(input logic [8:0] v0, input logic [8:0] v1,
                            input logic [8:0] v2, input logic [8:0] v3,
                            input int d0, input int d1, input int d2);
        vec0 = v0; vec1 = v1; vec2 = v2; vec3 = v3;
        duty0 = d0[7:0]; duty1 = d1[7:0]; duty2 = d2[7:0];
        load = 1'b1;
        @(posedge clk); #2;
        load = 1'b0;
        m_pend[0] = v0; m_pend[1] = v1; m_pend[2] = v2; m_pend[3] = v3;
        m_pendd[0] = d0; m_pendd[1] = d1; m_pendd[2] = d2;
        m_pend_ok = 1;
    endtask

    // Driver: waits for a period start and pushes one expected item per cycle.
    task automatic run_period(input string tag);
        int p;
        int cum;
        int t [3];
        logic [8:0] sel;
        item_t it;
        do begin
            @(posedge clk); #2;
        end while (!period_start);
        if (m_pend_ok) begin
            for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
            for (int i = 0; i < 3; i++) m_actd[i] = m_pendd[i];
            m_run = 1;
            m_pend_ok = 0;
        end
        p = int'(period_cycles);
        cum = 0;
        for (int k = 0; k < 3; k++) begin
            cum = cum + m_actd[k];
            t[k] = (((cum > 256) ? 256 : cum) * p + 128) >> 8;
        end
        for (int i = 0; i < p; i++) begin
            if (!m_run)        sel = '0;
            else if (i < t[0]) sel = m_act[0];
            else if (i < t[1]) sel = m_act[1];
            else if (i < t[2]) sel = m_act[2];
            else               sel = m_act[3];
            it.a = sel[2:0]; it.b = sel[5:3]; it.c = sel[8:6];
            it.stb = (i == 0);
            it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    // Monitor: one comparison per cycle, away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t e;
            e = exp_q.pop_front();
            checks++;
            if (lvl_a !== e.a || lvl_b !== e.b || lvl_c !== e.c || period_start !== e.stb) begin
                errors++;
                $display("FAIL %s: a/b/c/stb actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                         e.tag, lvl_a, lvl_b, lvl_c, period_start, e.a, e.b, e.c, e.stb);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R2 watchdog: actual run still busy, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        load = 1'b0;
        period_cycles = 16'd10;
        vec0 = '0; vec1 = '0; vec2 = '0; vec3 = '0;
        duty0 = '0; duty1 = '0; duty2 = '0;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (lvl_a !== 3'd0 || lvl_b !== 3'd0 || lvl_c !== 3'd0 || period_start !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: a/b/c/stb actual %0d/%0d/%0d/%0d expected 0/0/0/0",
                     lvl_a, lvl_b, lvl_c, period_start);
        end
        rst_n = 1'b1;

        // R1: idle period; the set loaded inside it must not show yet (R7).
        run_period("R1 R7");
        load_set({3'd1, 3'd1, 3'd1}, {3'd1, 3'd1, 3'd2}, {3'd1, 3'd2, 3'd2}, {3'd2, 3'd2, 3'd2},
                 64, 96, 32);
        // R4 / R9: full four-step sequence, T = 3, 6, 8 of 10.
        run_period("R4 R9");
        // R8: no new load, same set again; B loaded here must wait (R7).
        run_period("R8");
        load_set({3'd4, 3'd3, 3'd0}, {3'd4, 3'd4, 3'd0}, {3'd5, 3'd4, 3'd0}, {3'd5, 3'd4, 3'd1},
                 0, 100, 0);
        run_period("R7");
        // R6: zero shares skip V0 and V2.
        run_period("R6");
        // R5: over-full duty sum clamps; R2: new length 7 from the next period.
        load_set({3'd0, 3'd0, 3'd0}, {3'd0, 3'd0, 3'd1}, {3'd0, 3'd1, 3'd1}, {3'd1, 3'd1, 3'd1},
                 200, 100, 50);
        period_cycles = 16'd7;
        run_period("R5 R2");
        run_period("R2");
        // R3: 128/256 of 7 cycles rounds 3.5 up to 4.
        load_set({3'd6, 3'd2, 3'd5}, {3'd6, 3'd2, 3'd6}, {3'd7, 3'd2, 3'd6}, {3'd7, 3'd3, 3'd6},
                 128, 0, 128);
        run_period("R3");
        while (exp_q.size() > 0) @(negedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule